// File: doc/BRIEF.md
# I2C Slave Command Decoder

This block is the two-wire serial front end of a peripheral. A system clock much faster than the bus clock oversamples SCL and SDA, and the block finds start, repeated-start and stop conditions from the sampled levels. It answers to one of two 7-bit addresses, chosen by a select pin, and acknowledges by pulling an open-drain SDA low. In a write, the first byte is an opcode whose top bit sets the command length. The block acknowledges exactly that many bytes, refuses any surplus, and gives each finished command to the register side as a single-cycle strobe.

The block also holds an 8-bit interrupt request register. Event inputs set its bits. A read transfer returns the register. A two-byte write with the clear opcode clears the bits that its data byte marks. A mode pin turns the serial interface on or off. Holding the mode pin and the enable pin both low resets the block, including the interrupt register.

Top module: `i2c_cmd_slave`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. After a stop, the block ignores bus traffic until the next start: it gives no acknowledge and no strobe.
- R2: With `addr_sel` low the block answers address bytes 28h (write) and 29h (read). With `addr_sel` high it answers 2Ah and 2Bh. It ignores any other address byte.
- R3: For each accepted byte, `sda_oe` is high during the ninth SCL pulse. It drops after that pulse's falling edge, before the next bit. `sda_oe` changes only while SCL is low.
- R4: An opcode with bit 7 clear is a one-byte command. Its strobe carries `cmd_arg` = 00h. An opcode with bit 7 set takes one more data byte, and the strobe comes after that byte, with the byte in `cmd_arg`. `cmd_valid` is high for one cycle per command.
- R5: Bytes beyond a command's length are not acknowledged (SDA left high) and produce no strobe.
- R6: A start that arrives without a stop ends the current sequence and begins a new address phase. Commands chained this way each produce their own strobe.
- R7: Address bit 0 set selects a read. The block returns the interrupt register MSB first and sends it again while the master acknowledges. After a master NACK it stops driving SDA until the next start.
- R8: A high bit on `irq_evt` sets the matching register bit on the next clock, and an event wins over a clear in the same cycle. `irq_o` is the OR of the register bits. The command 8Fh followed by a mask byte clears the bits that are 1 in the mask.
- R9: While `mode_sel` is high, the block drives no SDA, acknowledges nothing and produces no strobe.
- R10: While `mode_sel` and `bus_en` are both low, the block is held in reset: the interrupt register is zero and SDA is released.
- R11: After `rst`, `sda_oe`, `cmd_valid` and `irq_o` are all low.
- R12: If the address byte does not match, the block sends a NACK and ignores the rest of that transfer until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 cycles per SCL period |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | Low enables the two-wire interface |
| bus_en | input | 1 | Low together with a low `mode_sel` holds the block in reset |
| addr_sel | input | 1 | Chooses between the two slave addresses |
| scl_i | input | 1 | Bus clock as seen on the pin |
| sda_i | input | 1 | Bus data as seen on the pin |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| irq_evt | input | 8 | Event pulses that set interrupt request bits |
| irq_o | output | 1 | High while any interrupt request bit is set |
| cmd_valid | output | 1 | One-cycle strobe for a finished command |
| cmd_op | output | 8 | Opcode of the strobed command |
| cmd_arg | output | 8 | Data byte of the strobed command, 00h for one-byte commands |

## Verification
The bench keeps the default parameters: two synchronizer stages, addresses 14h and 15h, and clear opcode 8Fh. It clocks the bus at 16 system cycles per bit. With two stages, the slave's SDA changes land well inside the low half of SCL. The addresses give both slots (28h/2Ah) and both mismatch cases. With 8Fh, the same opcode path exercises the two-byte length rule and the interrupt-clear side effect, which a read can then confirm. Because the bus is slow, repeated starts, master NACKs and surplus bytes can each be timed and sampled at mid-phase.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_END,
        ST_ACK,
        ST_TX,
        ST_TX_END,
        ST_MACK,
        ST_MACK_END,
        ST_SKIP
    } bus_st_t;

    typedef struct packed {
        byte_t op;
        byte_t arg;
    } cmd_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    // Number of bytes a write command occupies, opcode included.
    function automatic logic [1:0] cmd_len(byte_t op);
        return op[BYTE_W-1] ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_cmd_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_p;
    logic              sda_p;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ff[g] <= 1'b1;
                    sda_ff[g] <= 1'b1;
                end else begin
                    scl_ff[g] <= scl_i;
                    sda_ff[g] <= sda_i;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ff[g] <= 1'b1;
                    sda_ff[g] <= 1'b1;
                end else begin
                    scl_ff[g] <= scl_ff[g-1];
                    sda_ff[g] <= sda_ff[g-1];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_ff[STAGES-1];
            sda_p <= sda_ff[STAGES-1];
        end
    end

    always_comb begin
        ev.scl      = scl_ff[STAGES-1];
        ev.sda      = sda_ff[STAGES-1];
        ev.scl_rise = ev.scl & ~scl_p;
        ev.scl_fall = ~ev.scl & scl_p;
        ev.start    = ev.scl & scl_p & sda_p & ~ev.sda;
        ev.stop     = ev.scl & scl_p & ~sda_p & ev.sda;
    end

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
    import i2c_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       active,
    input  logic [6:0] my_addr,
    input  line_ev_t   ev,
    input  byte_t      irq_in,
    output logic       sda_oe,
    output logic       cmd_valid,
    output cmd_t       cmd
);

    bus_st_t    st;
    logic [2:0] cnt;
    byte_t      sh;
    byte_t      tx;
    byte_t      op_q;
    logic [1:0] nbytes;
    logic       is_addr;
    logic       rw;
    logic       m_ack;
    logic       oe_q;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            sh        <= '0;
            tx        <= '0;
            op_q      <= '0;
            nbytes    <= '0;
            is_addr   <= 1'b0;
            rw        <= 1'b0;
            m_ack     <= 1'b0;
            oe_q      <= 1'b0;
            cmd_valid <= 1'b0;
            cmd       <= '0;
        end else begin
            cmd_valid <= 1'b0;
            if (ev.start) begin
                st      <= ST_RX;
                is_addr <= 1'b1;
                cnt     <= '0;
                oe_q    <= 1'b0;
            end else if (ev.stop) begin
                st   <= ST_IDLE;
                oe_q <= 1'b0;
            end else begin
                case (st)
                    ST_RX: begin
                        if (ev.scl_rise) begin
                            sh  <= {sh[BYTE_W-2:0], ev.sda};
                            cnt <= cnt + 3'd1;
                            if (cnt == 3'd7) st <= ST_RX_END;
                        end
                    end
                    ST_RX_END: begin
                        if (ev.scl_fall) begin
                            if (is_addr) begin
                                is_addr <= 1'b0;
                                if (sh[7:1] == my_addr) begin
                                    oe_q   <= 1'b1;
                                    rw     <= sh[0];
                                    nbytes <= '0;
                                    st     <= ST_ACK;
                                end else begin
                                    st <= ST_SKIP;
                                end
                            end else begin
                                rw <= 1'b0;
                                st <= ST_ACK;
                                if (nbytes == 2'd0) begin
                                    oe_q   <= 1'b1;
                                    op_q   <= sh;
                                    nbytes <= 2'd1;
                                    if (cmd_len(sh) == 2'd1) begin
                                        cmd_valid <= 1'b1;
                                        cmd.op    <= sh;
                                        cmd.arg   <= '0;
                                    end
                                end else if (nbytes < cmd_len(op_q)) begin
                                    oe_q      <= 1'b1;
                                    nbytes    <= nbytes + 2'd1;
                                    cmd_valid <= 1'b1;
                                    cmd.op    <= op_q;
                                    cmd.arg   <= sh;
                                end
                            end
                        end
                    end
                    ST_ACK: begin
                        if (ev.scl_fall) begin
                            cnt <= '0;
                            if (rw) begin
                                tx   <= irq_in;
                                oe_q <= ~irq_in[BYTE_W-1];
                                st   <= ST_TX;
                            end else begin
                                oe_q <= 1'b0;
                                st   <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev.scl_rise) begin
                            cnt <= cnt + 3'd1;
                            if (cnt == 3'd7) st <= ST_TX_END;
                        end else if (ev.scl_fall) begin
                            tx   <= {tx[BYTE_W-2:0], 1'b0};
                            oe_q <= ~tx[BYTE_W-2];
                        end
                    end
                    ST_TX_END: begin
                        if (ev.scl_fall) begin
                            oe_q <= 1'b0;
                            st   <= ST_MACK;
                        end
                    end
                    ST_MACK: begin
                        if (ev.scl_rise) begin
                            m_ack <= ~ev.sda;
                            st    <= ST_MACK_END;
                        end
                    end
                    ST_MACK_END: begin
                        if (ev.scl_fall) begin
                            if (m_ack) begin
                                tx   <= irq_in;
                                oe_q <= ~irq_in[BYTE_W-1];
                                cnt  <= '0;
                                st   <= ST_TX;
                            end else begin
                                st <= ST_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe = oe_q;

    // R3
    oe_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(oe_q) && $past(active) && !$past(ev.start) && !$past(ev.stop))
            |-> !$past(ev.scl));

    // R4
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    // R9
    gate_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !active |=> (!oe_q && !cmd_valid));

endmodule

// File: rtl/i2c_irq_reg.sv
module i2c_irq_reg
    import i2c_cmd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  byte_t evt,
    input  logic  clr,
    input  byte_t clr_mask,
    output byte_t bits
);

    byte_t irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= '0;
        end else begin
            irq_q <= (irq_q & ~(clr ? clr_mask : byte_t'(0))) | evt;
        end
    end

    assign bits = irq_q;

    // R8
    irq_set_chk: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((irq_q & $past(evt)) == $past(evt)));

endmodule

// File: rtl/i2c_cmd_slave.sv
module i2c_cmd_slave
    import i2c_cmd_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] ADDR_LO     = 7'h14,
    parameter logic [6:0] ADDR_HI     = 7'h15,
    parameter logic [7:0] IRQ_CLR_OP  = 8'h8F
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_sel,
    input  logic       bus_en,
    input  logic       addr_sel,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [7:0] irq_evt,
    output logic       irq_o,
    output logic       cmd_valid,
    output logic [7:0] cmd_op,
    output logic [7:0] cmd_arg
);

    logic     rst_int;
    logic     active;
    line_ev_t ev;
    cmd_t     cmd;
    byte_t    irq_bits;
    logic     clr;

    assign rst_int = rst | (~mode_sel & ~bus_en);
    assign active  = ~mode_sel;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst_int),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_slave_fsm u_fsm (
        .clk       (clk),
        .rst       (rst_int),
        .active    (active),
        .my_addr   (addr_sel ? ADDR_HI : ADDR_LO),
        .ev        (ev),
        .irq_in    (irq_bits),
        .sda_oe    (sda_oe),
        .cmd_valid (cmd_valid),
        .cmd       (cmd)
    );

    assign clr = cmd_valid && (cmd.op == IRQ_CLR_OP);

    i2c_irq_reg u_irq (
        .clk      (clk),
        .rst      (rst_int),
        .evt      (irq_evt),
        .clr      (clr),
        .clr_mask (cmd.arg),
        .bits     (irq_bits)
    );

    assign irq_o   = |irq_bits;
    assign cmd_op  = cmd.op;
    assign cmd_arg = cmd.arg;

    // R10
    bus_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_sel && !bus_en) |=> (irq_bits == '0 && !sda_oe));

endmodule

// File: tb/i2c_cmd_slave_bench.sv
module i2c_cmd_slave_bench;

    localparam int Q = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_sel = 1'b0;
    logic       bus_en = 1'b1;
    logic       addr_sel = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic [7:0] irq_evt = 8'h00;
    logic       irq_o;
    logic       cmd_valid;
    logic [7:0] cmd_op;
    logic [7:0] cmd_arg;

    int checks = 0;
    int errors = 0;
    int n_cmd = 0;
    logic [7:0] last_op = 8'h00;
    logic [7:0] last_arg = 8'h00;
    logic oe_stuck = 1'b0;
    bit done = 1'b0;

    assign sda_line = m_sda & ~sda_oe;

    always #5 clk = ~clk;

    i2c_cmd_slave u_i2c_cmd_slave (
        .clk       (clk),
        .rst       (rst),
        .mode_sel  (mode_sel),
        .bus_en    (bus_en),
        .addr_sel  (addr_sel),
        .scl_i     (m_scl),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .irq_evt   (irq_evt),
        .irq_o     (irq_o),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_arg   (cmd_arg)
    );

    always @(negedge clk) begin
        if (cmd_valid) begin
            n_cmd    <= n_cmd + 1;
            last_op  <= cmd_op;
            last_arg <= cmd_arg;
        end
    end

    typedef struct packed {
        logic       sel;
        logic [7:0] ab;
        logic [7:0] b0;
        logic [7:0] b1;
        logic [7:0] b2;
        logic [1:0] n;
        logic [3:0] ack;
        logic [1:0] ncmd;
        logic [7:0] op;
        logic [7:0] arg;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h28, 8'h05, 8'h00, 8'h00, 2'd1, 4'b1100, 2'd1, 8'h05, 8'h00},
        '{1'b0, 8'h28, 8'h05, 8'h33, 8'h00, 2'd2, 4'b1100, 2'd1, 8'h05, 8'h00},
        '{1'b0, 8'h28, 8'hA1, 8'h5C, 8'h00, 2'd2, 4'b1110, 2'd1, 8'hA1, 8'h5C},
        '{1'b0, 8'h28, 8'hA1, 8'h5C, 8'h77, 2'd3, 4'b1110, 2'd1, 8'hA1, 8'h5C},
        '{1'b0, 8'h2A, 8'h05, 8'h00, 8'h00, 2'd1, 4'b0000, 2'd0, 8'h00, 8'h00},
        '{1'b1, 8'h2A, 8'h7F, 8'h00, 8'h00, 2'd1, 4'b1100, 2'd1, 8'h7F, 8'h00},
        '{1'b1, 8'h28, 8'h90, 8'h11, 8'h00, 2'd2, 4'b0000, 2'd0, 8'h00, 8'h00},
        '{1'b0, 8'h28, 8'h80, 8'hFF, 8'h00, 2'd2, 4'b1110, 2'd1, 8'h80, 8'hFF},
        '{1'b1, 8'h2A, 8'hFE, 8'h01, 8'h00, 2'd2, 4'b1110, 2'd1, 8'hFE, 8'h01}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(2*Q);
        m_sda = 1'b0; tick(2*Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(2*Q);
        m_sda = 1'b1; tick(2*Q);
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(Q);
            m_scl = 1'b1; tick(2*Q);
            m_scl = 1'b0; tick(Q);
        end
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        ack = ~sda_line;
        tick(Q);
        m_scl = 1'b0; tick(Q);
        if (sda_oe) oe_stuck = 1'b1;
    endtask

    task automatic rbyte(input logic give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(2*Q);
            m_scl = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q);
            m_scl = 1'b0;
        end
        tick(Q);
        m_sda = give_ack ? 1'b0 : 1'b1; tick(Q);
        m_scl = 1'b1; tick(2*Q);
        m_scl = 1'b0; tick(Q);
        m_sda = 1'b1;
    endtask

    task automatic pulse_evt(input logic [7:0] e);
        irq_evt = e; tick(1);
        irq_evt = 8'h00;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic       a;
        logic [3:0] got;
        logic [3:0] mask;
        logic [7:0] rb;
        int         n0;

        tick(5);
        rst = 1'b0;
        tick(2);
        // R11 reset state
        chk(sda_oe == 1'b0, "R11 sda_oe after reset", sda_oe, 0);
        chk(cmd_valid == 1'b0, "R11 cmd_valid after reset", cmd_valid, 0);
        chk(irq_o == 1'b0, "R11 irq_o after reset", irq_o, 0);

        // Table walk: R2 R4 R5 R12 R3
        for (int v = 0; v < NV; v++) begin
            addr_sel = VECS[v].sel;
            oe_stuck = 1'b0;
            tick(2);
            n0 = n_cmd;
            got = 4'b0000;
            mask = 4'b1000;
            bus_start();
            wbyte(VECS[v].ab, a);
            got[3] = a;
            for (int k = 0; k < 3; k++) begin
                if (k < int'(VECS[v].n)) begin
                    wbyte(k == 0 ? VECS[v].b0 : (k == 1 ? VECS[v].b1 : VECS[v].b2), a);
                    got[2-k] = a;
                    mask[2-k] = 1'b1;
                end
            end
            bus_stop();
            tick(4);
            chk((got & mask) == (VECS[v].ack & mask), $sformatf("R2/R5/R12 ack pattern vec %0d", v), got & mask, VECS[v].ack & mask);
            chk(n_cmd - n0 == int'(VECS[v].ncmd), $sformatf("R4 strobe count vec %0d", v), n_cmd - n0, VECS[v].ncmd);
            chk(!oe_stuck, $sformatf("R3 sda released after ack vec %0d", v), oe_stuck, 0);
            if (VECS[v].ncmd != 0)
                chk(last_op == VECS[v].op && last_arg == VECS[v].arg, $sformatf("R4 op/arg vec %0d", v),
                    {last_op, last_arg}, {VECS[v].op, VECS[v].arg});
        end
        addr_sel = 1'b0;

        // R8 set, R7 read with repeat then NACK
        pulse_evt(8'hA5);
        tick(1);
        chk(irq_o == 1'b1, "R8 irq_o after event", irq_o, 1);
        bus_start();
        wbyte(8'h29, a);
        chk(a == 1'b1, "R7 read address ack", a, 1);
        rbyte(1'b1, rb);
        chk(rb == 8'hA5, "R7 first read byte", rb, 8'hA5);
        rbyte(1'b0, rb);
        chk(rb == 8'hA5, "R7 second read byte", rb, 8'hA5);
        oe_stuck = 1'b0;
        for (int k = 0; k < 8; k++) begin
            tick(1);
            if (sda_oe) oe_stuck = 1'b1;
        end
        m_scl = 1'b1;
        for (int k = 0; k < 8; k++) begin
            tick(1);
            if (sda_oe) oe_stuck = 1'b1;
        end
        m_scl = 1'b0; tick(Q);
        chk(!oe_stuck, "R7 released after master NACK", oe_stuck, 0);
        bus_stop();

        // R8 clear with mask, R6 repeated start into read
        n0 = n_cmd;
        bus_start();
        wbyte(8'h28, a);
        wbyte(8'h8F, a);
        wbyte(8'h05, a);
        bus_stop();
        tick(4);
        chk(irq_o == 1'b1, "R8 partial clear keeps irq", irq_o, 1);
        bus_start();
        wbyte(8'h28, a);
        wbyte(8'h03, a);
        bus_start();
        wbyte(8'h29, a);
        chk(a == 1'b1, "R6 read address after repeated start", a, 1);
        rbyte(1'b0, rb);
        bus_stop();
        tick(4);
        chk(rb == 8'hA0, "R8 mask cleared bits", rb, 8'hA0);
        chk(n_cmd - n0 == 2 && last_op == 8'h03, "R6 chained commands", n_cmd - n0, 2);

        n0 = n_cmd;
        bus_start();
        wbyte(8'h28, a);
        wbyte(8'h11, a);
        bus_start();
        wbyte(8'h28, a);
        wbyte(8'h22, a);
        bus_stop();
        tick(4);
        chk(n_cmd - n0 == 2 && last_op == 8'h22, "R6 write after repeated start", n_cmd - n0, 2);

        bus_start();
        wbyte(8'h28, a);
        wbyte(8'h8F, a);
        wbyte(8'hA0, a);
        bus_stop();
        tick(4);
        chk(irq_o == 1'b0, "R8 full clear", irq_o, 0);

        // R1 traffic after stop is ignored
        n0 = n_cmd;
        m_scl = 1'b0; tick(Q);
        wbyte(8'h28, a);
        m_scl = 1'b1; tick(2*Q);
        chk(a == 1'b0, "R1 no ack without start", a, 0);
        chk(n_cmd == n0, "R1 no strobe without start", n_cmd - n0, 0);

        // R9 interface gated off
        pulse_evt(8'h40);
        mode_sel = 1'b1;
        tick(4);
        n0 = n_cmd;
        bus_start();
        wbyte(8'h28, a);
        chk(a == 1'b0, "R9 no ack while gated", a, 0);
        wbyte(8'h05, a);
        bus_stop();
        tick(4);
        chk(n_cmd == n0, "R9 no strobe while gated", n_cmd - n0, 0);
        mode_sel = 1'b0;
        tick(4);
        chk(irq_o == 1'b1, "R9 irq kept while gated", irq_o, 1);

        // R10 pin reset
        bus_en = 1'b0;
        tick(3);
        bus_en = 1'b1;
        tick(2);
        chk(irq_o == 1'b0, "R10 irq cleared by pin reset", irq_o, 0);
        bus_start();
        wbyte(8'h29, a);
        rbyte(1'b0, rb);
        bus_stop();
        chk(a == 1'b1 && rb == 8'h00, "R10 register reads zero", rb, 8'h00);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule